// File: doc/BRIEF.md
# Buffered 16-bit Compare Channel

This block is one compare channel of a 16-bit timer/counter whose registers sit on an 8-bit bus. It takes the running counter value and checks it against a compare value in every cycle. It reports equality on a combinational match line. It raises a sticky compare flag one timer tick after a match has been seen, and it raises an interrupt request while that flag is set and interrupts are enabled. The channel can also hand its compare value to the counter as the period limit (TOP).

Software loads the 16-bit compare value one byte at a time. It writes the upper byte first, and that byte waits in a temporary latch. A later write of the lower byte moves both bytes into a holding register on a single clock edge. The holding register feeds the active register that the comparator uses. A mode input selects when that copy happens: on the lower-byte write itself, or at a later counter strobe.

Two small state machines make up the channel. The load machine has the states LD_IDLE and LD_WAIT. It goes from LD_IDLE to LD_WAIT on a lower-byte write in a deferred mode. It goes from LD_WAIT back to LD_IDLE on the selected strobe, and that transition copies the holding register into the active register. The flag machine has the states FL_CLR and FL_SET. It goes from FL_CLR to FL_SET on a tick whose previous tick saw a match. It goes from FL_SET back to FL_CLR on a clear request when no set arrives in the same cycle.

Top module: `cmp16_channel`

## Requirements
- R1: `match` is 1 exactly when `cnt` equals the active compare value, in the same cycle.
- R2: A tick during which `match` held causes `flag` to become 1 right after the next tick's clock edge, not earlier.
- R3: `irq` is 1 whenever `flag` is 1 and the interrupt-enable bit (control address 2, bit 1) is 1, and is 0 otherwise.
- R4: A cycle with `irq_ack` high clears `flag` at the following edge.
- R5: Writing control address 2 with bit 0 set clears `flag`; with bit 0 clear, `flag` keeps its value.
- R6: When a clear (write or acknowledge) and a flag-set event fall in the same cycle, `flag` ends up 1.
- R7: A write to address 1 (upper byte) changes only the temporary latch: the readable holding register and the active value stay unchanged.
- R8: A write to address 0 (lower byte) loads {latched upper byte, written byte} into the holding register in one clock. In mode 2'b00 it loads the same value into the active register on that edge.
- R9: In mode 2'b01 the active register takes the holding value at the first `at_top` after a lower-byte write. In mode 2'b10 this happens at `at_bottom` instead, and in mode 2'b11 at either strobe. The other strobe has no effect.
- R10: `top_val` equals the active compare value when `period_sel` is 1, and all ones otherwise.
- R11: Reset clears the temporary latch, the holding and active registers, the flag and the interrupt enable to zero.
- R12: Reading address 0 gives the holding register's lower byte and address 1 its upper byte. Address 2 gives {6'b0, enable, flag} and address 3 gives zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock enable |
| cnt | input | 16 | Current counter value |
| at_top | input | 1 | Counter is at its TOP this cycle |
| at_bottom | input | 1 | Counter is at BOTTOM this cycle |
| mode | input | 2 | Active-register update point: 00 at write, 01 TOP, 10 BOTTOM, 11 either |
| period_sel | input | 1 | This channel supplies the counter period |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 2 | Write address: 0 low, 1 high, 2 control |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data |
| irq_ack | input | 1 | Interrupt serviced; clears the flag |
| match | output | 1 | Counter equals active compare value |
| flag | output | 1 | Sticky compare flag |
| irq | output | 1 | Interrupt request |
| top_val | output | 16 | Period limit offered to the counter |

## Verification
A corrupted active register shows up at once on `top_val` when `period_sel` is set, and on `match` as soon as the counter reaches the wrong value. A stale temporary latch or holding register shows up when the holding register is read back. A load machine stuck in LD_WAIT or LD_IDLE leaves `top_val` wrong from the first strobe that should have moved the value. A flag machine in the wrong state is visible on `flag` and `irq` within one cycle. A missing or extra delay stage moves the rise of `flag` by one tick.

// File: rtl/cmp16_pkg.sv
package cmp16_pkg;
    typedef enum logic [1:0] {
        UPD_NOW = 2'b00,
        UPD_TOP = 2'b01,
        UPD_BOT = 2'b10,
        UPD_ANY = 2'b11
    } upd_mode_t;

    typedef enum logic { LD_IDLE, LD_WAIT } ld_state_t;
    typedef enum logic { FL_CLR, FL_SET } fl_state_t;

    localparam logic [1:0] ADDR_LO  = 2'd0;
    localparam logic [1:0] ADDR_HI  = 2'd1;
    localparam logic [1:0] ADDR_CTL = 2'd2;
endpackage

// File: rtl/cmp16_bytereg.sv
module cmp16_bytereg
    import cmp16_pkg::*;
#(
    parameter int CW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [BW-1:0] wr_data,
    input  logic [1:0]    mode,
    input  logic          at_top,
    input  logic          at_bottom,
    output logic [CW-1:0] hold_q,
    output logic [CW-1:0] act_q
);
    localparam int HW = CW - BW;

    logic [HW-1:0] temp_q;
    ld_state_t     st_q, st_d;
    logic          lo_wr, hi_wr, imm, strobe, load_now, xfer;
    logic [CW-1:0] joined;

    always_comb begin
        lo_wr  = wr_en && (wr_addr == ADDR_LO);
        hi_wr  = wr_en && (wr_addr == ADDR_HI);
        joined = {temp_q, wr_data};
        imm    = 1'b0;
        strobe = 1'b0;
        unique case (upd_mode_t'(mode))
            UPD_NOW: imm    = 1'b1;
            UPD_TOP: strobe = at_top;
            UPD_BOT: strobe = at_bottom;
            UPD_ANY: strobe = at_top || at_bottom;
        endcase
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LD_IDLE: if (lo_wr && !imm) st_d = LD_WAIT;
            LD_WAIT: begin
                if (lo_wr && !imm)  st_d = LD_WAIT;
                else if (strobe)    st_d = LD_IDLE;
            end
        endcase
    end

    // outputs of the load machine
    always_comb begin
        load_now = 1'b0;
        xfer     = 1'b0;
        unique case (st_q)
            LD_IDLE: load_now = lo_wr && imm;
            LD_WAIT: begin
                load_now = lo_wr && imm;
                xfer     = strobe;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LD_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            temp_q <= '0;
            hold_q <= '0;
            act_q  <= '0;
        end else begin
            if (hi_wr)         temp_q <= wr_data[HW-1:0];
            if (lo_wr)         hold_q <= joined;
            if (load_now)      act_q  <= joined;
            else if (xfer)     act_q  <= hold_q;
        end
    end
endmodule

// File: rtl/cmp16_flag.sv
module cmp16_flag
    import cmp16_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic match,
    input  logic clr_wr,
    input  logic ack,
    output logic pend,
    output logic flag
);
    fl_state_t st_q, st_d;
    logic      set_ev, clr_ev;

    always_comb begin
        set_ev = tick && pend;
        clr_ev = clr_wr || ack;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FL_CLR: if (set_ev)            st_d = FL_SET;
            FL_SET: if (clr_ev && !set_ev) st_d = FL_CLR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= FL_CLR;
            pend <= 1'b0;
        end else begin
            st_q <= st_d;
            if (tick) pend <= match;
        end
    end

    always_comb begin
        unique case (st_q)
            FL_CLR: flag = 1'b0;
            FL_SET: flag = 1'b1;
        endcase
    end
endmodule

// File: rtl/cmp16_channel.sv
module cmp16_channel
    import cmp16_pkg::*;
#(
    parameter int CW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [CW-1:0] cnt,
    input  logic          at_top,
    input  logic          at_bottom,
    input  logic [1:0]    mode,
    input  logic          period_sel,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [BW-1:0] wr_data,
    input  logic [1:0]    rd_addr,
    output logic [BW-1:0] rd_data,
    input  logic          irq_ack,
    output logic          match,
    output logic          flag,
    output logic          irq,
    output logic [CW-1:0] top_val
);
    logic [CW-1:0] hold_q, act_q;
    logic          pend, ie_q, ctl_wr;

    cmp16_bytereg #(.CW(CW), .BW(BW)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode(mode), .at_top(at_top), .at_bottom(at_bottom),
        .hold_q(hold_q), .act_q(act_q)
    );

    always_comb begin
        match  = (cnt == act_q);
        ctl_wr = wr_en && (wr_addr == ADDR_CTL);
    end

    cmp16_flag flag_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .match(match),
        .clr_wr(ctl_wr && wr_data[0]), .ack(irq_ack),
        .pend(pend), .flag(flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ie_q <= 1'b0;
        else if (ctl_wr) ie_q <= wr_data[1];
    end

    always_comb begin
        irq     = flag && ie_q;
        top_val = period_sel ? act_q : '1;
        unique case (rd_addr)
            2'd0: rd_data = hold_q[BW-1:0];
            2'd1: rd_data = BW'(hold_q[CW-1:BW]);
            2'd2: rd_data = {{(BW-2){1'b0}}, ie_q, flag};
            2'd3: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/cmp16_chk.sv
module cmp16_chk #(
    parameter int CW = 16,
    parameter int BW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          pend,
    input logic          flag,
    input logic          irq_ack,
    input logic          wr_en,
    input logic [1:0]    wr_addr,
    input logic [BW-1:0] wr_data,
    input logic [1:0]    mode,
    input logic          at_top,
    input logic          at_bottom,
    input logic [CW-1:0] hold_q,
    input logic [CW-1:0] act_q
);
    a_r2_flag_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pend) |=> flag);

    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !(tick && pend)) |=> !flag);

    a_r5_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd2 && !wr_data[0] && !irq_ack && flag) |=> flag);

    a_r7_hi_write_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1) |=> $stable(hold_q));

    a_r9_no_strobe_no_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00 && !at_top && !at_bottom) |=> $stable(act_q));
endmodule

bind cmp16_channel cmp16_chk #(.CW(CW), .BW(BW)) chk_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pend(pend), .flag(flag),
    .irq_ack(irq_ack), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode(mode), .at_top(at_top), .at_bottom(at_bottom),
    .hold_q(hold_q), .act_q(act_q)
);

// File: tb/cmp16_channel_tb_top.sv
module cmp16_channel_tb_top;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [15:0] cnt = '0;
    logic        at_top = 1'b0, at_bottom = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        period_sel = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        irq_ack = 1'b0;
    logic        match, flag, irq;
    logic [15:0] top_val;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference state
    logic [7:0]  m_temp = '0;
    logic [15:0] m_hold = '0, m_act = '0;
    logic        m_wait = 0, m_pend = 0, m_flag = 0, m_ie = 0;

    always #(CLK_NS/2) clk = ~clk;

    cmp16_channel dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .at_top(at_top),
        .at_bottom(at_bottom), .mode(mode), .period_sel(period_sel),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_ack(irq_ack), .match(match), .flag(flag),
        .irq(irq), .top_val(top_val)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_hold[7:0];
            2'd1: return m_hold[15:8];
            2'd2: return {6'b0, m_ie, m_flag};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic strobe_of(input logic [1:0] md, input logic t, input logic b);
        case (md)
            2'b01: return t;
            2'b10: return b;
            2'b11: return t || b;
            default: return 1'b0;
        endcase
    endfunction

    // one clock: model next state from current inputs, take edge, compare
    task automatic cyc();
        logic lo, hi, ct, stb, setv, clrv;
        logic [7:0]  n_temp;
        logic [15:0] n_hold, n_act;
        logic        n_wait, n_pend, n_flag, n_ie;
        lo = wr_en && wr_addr == 2'd0;
        hi = wr_en && wr_addr == 2'd1;
        ct = wr_en && wr_addr == 2'd2;
        stb = strobe_of(mode, at_top, at_bottom);
        n_temp = hi ? wr_data : m_temp;
        n_hold = lo ? {m_temp, wr_data} : m_hold;
        if (lo && mode == 2'b00)  n_act = {m_temp, wr_data};
        else if (m_wait && stb)   n_act = m_hold;
        else                      n_act = m_act;
        if (lo && mode != 2'b00)  n_wait = 1'b1;
        else if (m_wait && stb)   n_wait = 1'b0;
        else                      n_wait = m_wait;
        n_pend = tick ? (cnt == m_act) : m_pend;
        setv = tick && m_pend;
        clrv = (ct && wr_data[0]) || irq_ack;
        n_flag = setv || (m_flag && !clrv);
        n_ie = ct ? wr_data[1] : m_ie;
        @(posedge clk);
        #1;
        m_temp = n_temp; m_hold = n_hold; m_act = n_act; m_wait = n_wait;
        m_pend = n_pend; m_flag = n_flag; m_ie = n_ie;
        chk("R1 match", 16'(match), 16'(cnt == m_act));
        chk("R2 flag", 16'(flag), 16'(m_flag));
        chk("R3 irq", 16'(irq), 16'(m_flag && m_ie));
        chk("R10 top_val", top_val, period_sel ? m_act : 16'hFFFF);
        chk("R12 rd_data", 16'(rd_data), 16'(exp_rd(rd_addr)));
    endtask

    task automatic idle_in();
        wr_en = 0; tick = 0; at_top = 0; at_bottom = 0; irq_ack = 0;
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        idle_in();
        wr_en = 1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 0;
    endtask

    initial begin
        #(CLK_NS * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        #(CLK_NS * 3);
        #1;
        // R11 reset state
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a);
            #1;
            chk("R11 reset rd", 16'(rd_data), 16'h0);
        end
        chk("R11 reset top", top_val, 16'h0000);
        chk("R11 reset flag", 16'(flag), 16'h0);
        @(negedge clk);
        rst_n = 1;
        idle_in();
        cyc();

        // R7: upper byte waits in the latch only
        rd_addr = 2'd1;
        bus_wr(2'd1, 8'h12);
        chk("R7 hold hi untouched", 16'(rd_data), 16'h0);
        chk("R7 active untouched", top_val, 16'h0000);

        // R8: lower byte joins, immediate mode
        rd_addr = 2'd0;
        bus_wr(2'd0, 8'h34);
        chk("R8 active loaded", top_val, 16'h1234);
        chk("R8 hold lo", 16'(rd_data), 16'h34);

        // R9: deferred to TOP; BOTTOM ignored
        mode = 2'b01;
        bus_wr(2'd1, 8'hAB);
        bus_wr(2'd0, 8'hCD);
        chk("R9 held before strobe", top_val, 16'h1234);
        idle_in(); at_bottom = 1; cyc();
        chk("R9 bottom ignored in TOP mode", top_val, 16'h1234);
        idle_in(); at_top = 1; cyc();
        chk("R9 copied at top", top_val, 16'hABCD);
        // R9: BOTTOM mode
        mode = 2'b10;
        bus_wr(2'd1, 8'h00);
        bus_wr(2'd0, 8'h77);
        idle_in(); at_top = 1; cyc();
        chk("R9 top ignored in BOTTOM mode", top_val, 16'hABCD);
        idle_in(); at_bottom = 1; cyc();
        chk("R9 copied at bottom", top_val, 16'h0077);
        mode = 2'b00;
        period_sel = 0; idle_in(); cyc();
        chk("R10 no period source", top_val, 16'hFFFF);
        period_sel = 1;

        // R2: flag one tick after the matching tick
        idle_in(); cnt = 16'h0077; tick = 1; cyc();
        chk("R2 not in match tick", 16'(flag), 16'h0);
        idle_in(); cnt = 16'h0000; cyc();
        chk("R2 not without tick", 16'(flag), 16'h0);
        tick = 1; cyc();
        chk("R2 set next tick", 16'(flag), 16'h1);

        // R3 / R5
        rd_addr = 2'd2;
        bus_wr(2'd2, 8'h02);
        chk("R3 irq on", 16'(irq), 16'h1);
        chk("R5 zero keeps flag", 16'(flag), 16'h1);
        bus_wr(2'd2, 8'h03);
        chk("R5 one clears flag", 16'(flag), 16'h0);
        chk("R3 irq off", 16'(irq), 16'h0);

        // R6: clear and set in one cycle
        idle_in(); cnt = 16'h0077; tick = 1; cyc();
        idle_in(); tick = 1; wr_en = 1; wr_addr = 2'd2; wr_data = 8'h03; cyc();
        chk("R6 set wins", 16'(flag), 16'h1);

        // R4: acknowledge
        idle_in(); cnt = 16'h0000; irq_ack = 1; cyc();
        chk("R4 ack clears", 16'(flag), 16'h0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            idle_in();
            tick = ($urandom % 2) == 0;
            cnt = (($urandom % 3) == 0) ? m_act : 16'($urandom % 8);
            at_top = ($urandom % 6) == 0;
            at_bottom = ($urandom % 6) == 0;
            irq_ack = ($urandom % 12) == 0;
            if (($urandom % 50) == 0) mode = 2'($urandom);
            period_sel = ($urandom % 4) != 0;
            rd_addr = 2'($urandom);
            if (($urandom % 4) == 0) begin
                wr_en = 1;
                wr_addr = 2'($urandom % 3);
                wr_data = 8'($urandom % 8);
            end
            cyc();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule